// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a target on a two-wire serial bus (I2C/SMBus style, 7-bit addressing) that gives a host access to a small byte-wide configuration store of 48 locations. The host writes a command byte after the address. Its top bit picks a single-byte access or a sequential block access, and its low seven bits give the starting offset. Writes land in the store as soon as each byte completes. Block writes walk upward through the offsets and may end after any whole byte. Reads return one byte in single mode. In block mode they return exactly the number of bytes held in a programmable count field, and the block then lets go of the data line.

SCL and SDA are brought into the system clock through two-flop synchronisers and oversampled. The system clock must run at least eight times the bus bit rate, which covers 100 and 400 kbit/s. An external busy flag stands for a nonvolatile programming cycle. While it is high, incoming data bytes are refused, but reads go on as normal. The open-drain output is modelled as a drive-low enable.

Every accepted write is also announced on a one-cycle write strobe carrying offset and data. This is a valid-only stream with no ready. The bus cannot be stalled, because clock stretching is not used, so a receiver of the strobe must take it in the cycle it appears. Back-pressure is not possible.

Top module: `twi_regslave`

## Requirements
- R1: The block answers an address byte whose upper seven bits equal 1100_1 followed by A1:A0 (bit 0 of the byte is read/write, 1 = read) with ACK. Any other address gets NACK, and the block ignores the bus until the next start condition.
- R2: A1:A0 are bits 1:0 of offset 1 (reset 00). A new value applies from the next transaction on.
- R3: Command byte bit 7 = 1 selects single-byte access and bit 7 = 0 selects block access. Bits 6:0 are the starting offset. The command byte is always ACKed once the address matches.
- R4: Each accepted data byte is stored at once at the current offset, and the offset then steps up by one. `wr_valid` pulses for exactly one cycle with that offset and byte.
- R5: In single-byte write mode, a second data byte in the same transaction is NACKed and not stored.
- R6: A block read returns exactly N bytes, where N is bits 7:1 of offset 6 (reset value 30h, so the byte reads 60h). After N bytes the data line stays released, so any further byte reads as FFh. A single read returns one byte.
- R7: While `prog_busy` is high, data bytes are NACKed and not stored, and reads work unchanged. Bit 6 of offset 1 reads back the live busy level.
- R8: Offset 0 reads as the identification byte {device bit 0, 3-bit revision = 2, 4-bit vendor = 1h} = 21h. Writes to it are ACKed but change nothing and raise no strobe.
- R9: Offsets 48 and above read as 00h. Writes to them are ACKed but change nothing and raise no strobe.
- R10: `sda_oe` changes only while the synchronised SCL is low, except when it is released by a start or stop. It is low after every stop.
- R11: After reset `sda_oe` and `wr_valid` are low, and all writable locations are 00h except offset 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| prog_busy | input | 1 | Nonvolatile programming in progress |
| wr_valid | output | 1 | One-cycle strobe for an accepted write |
| wr_addr | output | 7 | Offset of the accepted write |
| wr_data | output | 8 | Byte of the accepted write |

## Verification
Two functions meet on a single acknowledge bit in a block read. The host acknowledges the byte that uses up the byte count, and the block must then decide whether to release the line or load the next byte. The bench lowers the count to four, acknowledges every byte, and clocks one byte past the count. That byte must read FFh, and the bytes before it must match the model. A second overlap is the busy flag against a completing data byte. The bench raises busy between transactions, expects an ACKed command with a NACKed data byte, and then confirms through reads that neither the store nor the strobe changed.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_CMD, ST_CACK,
    ST_WDATA, ST_DACK, ST_RDATA, ST_MACK
  } twi_state_e;

  localparam logic [4:0] ADDR_PREFIX = 5'b11001;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic [1:0] pin_in, synced, prev;
  assign pin_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], pin_in[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 2'b11;
    else        prev <= synced;
  end

  assign scl_s    = synced[0];
  assign sda_s    = synced[1];
  assign scl_rise = synced[0] & ~prev[0];
  assign scl_fall = ~synced[0] & prev[0];
  assign start_c  = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_c   = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int         DEPTH     = 48,
  parameter int         ADR_OFF   = 1,
  parameter int         CNT_OFF   = 6,
  parameter int         BUSY_BIT  = 6,
  parameter logic [6:0] DEF_COUNT = 7'h30,
  parameter logic [7:0] ID_BYTE   = 8'h21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_busy,
  input  logic       wr_en,
  input  logic [6:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [6:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [1:0] slv_lo,
  output logic [6:0] blk_count
);
  localparam int         AW      = $clog2(DEPTH);
  localparam logic [6:0] DEPTH_W = 7'(DEPTH);
  localparam logic [6:0] ADR_W   = 7'(ADR_OFF);

  logic [7:0] mem [1:DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i < DEPTH; i++)
        mem[i] <= (i == CNT_OFF) ? {DEF_COUNT, 1'b0} : 8'h00;
    end else if (wr_en && wr_addr != 7'd0 && wr_addr < DEPTH_W) begin
      mem[wr_addr[AW-1:0]] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == 7'd0) begin
      rd_data = ID_BYTE;
    end else if (rd_addr < DEPTH_W) begin
      rd_data = mem[rd_addr[AW-1:0]];
      if (rd_addr == ADR_W) rd_data[BUSY_BIT] = prog_busy;
    end
  end

  assign slv_lo    = mem[ADR_OFF][1:0];
  assign blk_count = mem[CNT_OFF][7:1];
endmodule

// File: rtl/twi_engine.sv
module twi_engine
  import twi_pkg::*;
#(
  parameter int DEPTH = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_c,
  input  logic       stop_c,
  input  logic       prog_busy,
  input  logic [1:0] slv_lo,
  input  logic [6:0] blk_count,
  input  logic [7:0] rd_data,
  output logic [6:0] rd_addr,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [6:0] wr_addr,
  output logic [7:0] wr_data
);
  localparam logic [6:0] DEPTH_W = 7'(DEPTH);

  twi_state_e st;
  logic [3:0] bitn;
  logic [7:0] sr, tx;
  logic [6:0] ptr, left, first_len;
  logic       single, rw, wdone, mack;

  assign rd_addr   = ptr;
  assign first_len = single ? 7'd1 : blk_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitn <= '0; sr <= '0; tx <= '0; ptr <= '0; left <= '0;
      single <= 1'b0; rw <= 1'b0; wdone <= 1'b0; mack <= 1'b0;
      sda_oe <= 1'b0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        st <= ST_ADDR; bitn <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise && bitn < 4'd8) begin
              sr   <= {sr[6:0], sda_s};
              bitn <= bitn + 4'd1;
            end else if (scl_fall && bitn == 4'd8) begin
              bitn <= '0;
              if (st == ST_ADDR) begin
                if (sr[7:1] == {ADDR_PREFIX, slv_lo}) begin
                  rw <= sr[0]; sda_oe <= 1'b1; st <= ST_AACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_CMD) begin
                single <= sr[7]; ptr <= sr[6:0]; wdone <= 1'b0;
                sda_oe <= 1'b1; st <= ST_CACK;
              end else if (!prog_busy && !(single && wdone)) begin
                sda_oe <= 1'b1; wdone <= 1'b1; ptr <= ptr + 7'd1;
                st <= ST_DACK;
                if (ptr != 7'd0 && ptr < DEPTH_W) begin
                  wr_en <= 1'b1; wr_addr <= ptr; wr_data <= sr;
                end
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            if (!rw) begin
              sda_oe <= 1'b0; st <= ST_CMD;
            end else if (first_len == 7'd0) begin
              sda_oe <= 1'b0; st <= ST_IDLE;
            end else begin
              tx <= rd_data; sda_oe <= ~rd_data[7]; bitn <= '0;
              ptr <= ptr + 7'd1; left <= first_len - 7'd1; st <= ST_RDATA;
            end
          end
          ST_CACK, ST_DACK: if (scl_fall) begin
            sda_oe <= 1'b0; st <= ST_WDATA;
          end
          ST_RDATA: if (scl_fall) begin
            if (bitn == 4'd7) begin
              sda_oe <= 1'b0; bitn <= '0; st <= ST_MACK;
            end else begin
              tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; bitn <= bitn + 4'd1;
            end
          end
          ST_MACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack && left != 7'd0) begin
                tx <= rd_data; sda_oe <= ~rd_data[7]; ptr <= ptr + 7'd1;
                left <= left - 7'd1; st <= ST_RDATA;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_regslave.sv
module twi_regslave #(
  parameter int         DEPTH      = 48,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEF_COUNT  = 7'h30,
  parameter logic       DEV_BIT    = 1'b0,
  parameter logic [2:0] REV_ID     = 3'd2,
  parameter logic [3:0] VENDOR_ID  = 4'h1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       prog_busy,
  output logic       wr_valid,
  output logic [6:0] wr_addr,
  output logic [7:0] wr_data
);
  localparam logic [7:0] ID_BYTE = {DEV_BIT, REV_ID, VENDOR_ID};

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic [6:0] rd_addr, blk_count;
  logic [7:0] rd_data;
  logic [1:0] slv_lo;

  twi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(bus_start), .stop_c(bus_stop)
  );

  twi_engine #(.DEPTH(DEPTH)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_c(bus_start), .stop_c(bus_stop),
    .prog_busy(prog_busy), .slv_lo(slv_lo), .blk_count(blk_count),
    .rd_data(rd_data), .rd_addr(rd_addr), .sda_oe(sda_oe),
    .wr_en(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  twi_regfile #(
    .DEPTH(DEPTH), .DEF_COUNT(DEF_COUNT), .ID_BYTE(ID_BYTE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy),
    .wr_en(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .slv_lo(slv_lo), .blk_count(blk_count)
  );
endmodule

// File: rtl/twi_regslave_chk.sv
module twi_regslave_chk #(
  parameter int DEPTH = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_c,
  input logic       stop_c,
  input logic       sda_oe,
  input logic       prog_busy,
  input logic       wr_valid,
  input logic [6:0] wr_addr
);
  assert_no_write_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !$past(prog_busy));

  assert_write_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr != 7'd0 && int'(wr_addr) < DEPTH));

  assert_strobe_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_drive_on_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_release_on_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_s || $past(start_c || stop_c)));

  assert_released_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);
endmodule

bind twi_regslave twi_regslave_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_c(bus_start),
  .stop_c(bus_stop), .sda_oe(sda_oe), .prog_busy(prog_busy),
  .wr_valid(wr_valid), .wr_addr(wr_addr)
);

// File: tb/twi_regslave_test.sv
module twi_regslave_test;
  localparam int CLK_PERIOD = 10;
  localparam int TQ = 6;
  localparam logic [7:0] ID_EXP = 8'h21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, prog_busy = 1'b0;
  logic sda_oe, wr_valid, sda_line;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twi_regslave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .prog_busy(prog_busy),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_chk = 0, n_bad = 0, ev_cnt = 0;
  logic [6:0] ev_addr;
  logic [7:0] ev_data;
  logic [7:0] model [48];
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];
  bit wack [64];
  bit ack_a, ack_c, ack_a2, done = 1'b0;

  always @(posedge clk) if (rst_n && wr_valid) begin
    ev_cnt  <= ev_cnt + 1;
    ev_addr <= wr_addr;
    ev_data <= wr_data;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(int off);
    if (off >= 48) return 8'h00;
    if (off == 0) return ID_EXP;
    if (off == 1) return {model[1][7], prog_busy, model[1][5:0]};
    return model[off];
  endfunction

  task automatic wq(); repeat (TQ) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
    end
    wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = !sda_line;
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
    end
    wq(); sda_m = give_ack ? 1'b0 : 1'b1; wq(); scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [7:0] cmd, input int n);
    ack_c = 1'b0;
    for (int i = 0; i < n; i++) wack[i] = 1'b0;
    bus_start();
    send_byte({dev, 1'b0}, ack_a);
    if (ack_a) begin
      send_byte(cmd, ack_c);
      for (int i = 0; i < n; i++) send_byte(wbuf[i], wack[i]);
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] dev, input logic [7:0] cmd, input int n);
    ack_a2 = 1'b0;
    bus_start();
    send_byte({dev, 1'b0}, ack_a);
    send_byte(cmd, ack_c);
    bus_start();
    send_byte({dev, 1'b1}, ack_a2);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic model_wr(int off, logic [7:0] d);
    if (off >= 1 && off < 48) model[off] = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    int ev0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 48; i++) model[i] = 8'h00;
    model[6] = 8'h60;
    repeat (5) @(negedge clk);
    // R11: reset state
    chk("R11 sda_oe in reset", sda_oe, 0);
    chk("R11 wr_valid in reset", wr_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 sda_oe after reset", sda_oe, 0);

    // R6/R8/R11: default count 30h, block read from offset 0, plus one extra byte
    do_read(7'h64, 8'h00, 49);
    chk("R1 address ack", ack_a2, 1);
    chk("R8 id byte", rbuf[0], ID_EXP);
    for (int i = 1; i < 48; i++) chk("R6/R11 default block read", rbuf[i], exp_rd(i));
    chk("R6 released past default count", rbuf[48], 8'hFF);
    chk("R10 released after stop", sda_oe, 0);

    // R3: single read of offset 0
    do_read(7'h64, 8'h80, 1);
    chk("R3 single read id", rbuf[0], ID_EXP);

    // R1: wrong address NACK
    wbuf[0] = 8'h55;
    do_write(7'h65, 8'h89, 1);
    chk("R1 mismatch nack", ack_a, 0);
    do_read(7'h64, 8'h89, 1);
    chk("R1 mismatch left store unchanged", rbuf[0], 8'h00);

    // R2: program A1:A0 = 10
    wbuf[0] = 8'h02; ev0 = ev_cnt;
    do_write(7'h64, 8'h81, 1);
    model_wr(1, 8'h02);
    chk("R2 data ack", wack[0], 1);
    do_write(7'h64, 8'h81, 0);
    chk("R2 old address refused", ack_a, 0);
    do_read(7'h66, 8'h81, 1);
    chk("R2 new address accepted", ack_a2, 1);
    chk("R2 readback", rbuf[0], 8'h02);
    wbuf[0] = 8'h00;
    do_write(7'h66, 8'h81, 1);
    model_wr(1, 8'h00);

    // R4/R5: single write, second byte refused
    ev0 = ev_cnt; wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    do_write(7'h64, 8'h89, 2);
    model_wr(9, 8'hA5);
    chk("R5 first byte ack", wack[0], 1);
    chk("R5 second byte nack", wack[1], 0);
    chk("R4 one strobe", ev_cnt - ev0, 1);
    chk("R4 strobe offset", ev_addr, 9);
    chk("R4 strobe data", ev_data, 8'hA5);
    do_read(7'h64, 8'h8A, 1);
    chk("R5 next offset untouched", rbuf[0], 8'h00);

    // R4/R6: block write then count = 4
    ev0 = ev_cnt;
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h10 + 8'(i * 17);
    do_write(7'h64, 8'h0A, 4);
    for (int i = 0; i < 4; i++) model_wr(10 + i, wbuf[i]);
    chk("R4 block strobes", ev_cnt - ev0, 4);
    chk("R4 last strobe offset", ev_addr, 13);
    wbuf[0] = 8'h08;
    do_write(7'h64, 8'h86, 1);
    model_wr(6, 8'h08);
    do_read(7'h64, 8'h0A, 5);
    for (int i = 0; i < 4; i++) chk("R6 block read", rbuf[i], exp_rd(10 + i));
    chk("R6 count exhausted with ack", rbuf[4], 8'hFF);

    // R7: busy refuses data, reads continue
    prog_busy = 1'b1; ev0 = ev_cnt; wbuf[0] = 8'h77;
    do_write(7'h64, 8'h8C, 1);
    chk("R7 command ack while busy", ack_c, 1);
    chk("R7 data nack while busy", wack[0], 0);
    chk("R7 no strobe while busy", ev_cnt - ev0, 0);
    do_read(7'h64, 8'h8C, 1);
    chk("R7 store unchanged", rbuf[0], exp_rd(12));
    do_read(7'h64, 8'h81, 1);
    chk("R7 busy bit visible", rbuf[0], exp_rd(1));
    prog_busy = 1'b0;

    // R8: offset 0 is read-only
    ev0 = ev_cnt; wbuf[0] = 8'hFF;
    do_write(7'h64, 8'h80, 1);
    chk("R8 write ack", wack[0], 1);
    chk("R8 no strobe", ev_cnt - ev0, 0);
    do_read(7'h64, 8'h80, 1);
    chk("R8 id kept", rbuf[0], ID_EXP);

    // R9: beyond the store
    ev0 = ev_cnt; wbuf[0] = 8'h5A;
    do_write(7'h64, 8'hB2, 1);
    chk("R9 no strobe", ev_cnt - ev0, 0);
    do_read(7'h64, 8'hB2, 1);
    chk("R9 reads zero", rbuf[0], 8'h00);

    // random mix, R3/R4/R6
    for (int it = 0; it < 12; it++) begin
      int off = 7 + int'($urandom_range(0, 33));
      int len = 1 + int'($urandom_range(0, 3));
      bit blk = 1'($urandom_range(0, 1));
      if (!blk) len = 1;
      for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom);
      do_write(7'h64, {~blk, 7'(off)}, len);
      for (int i = 0; i < len; i++) begin
        chk("R4 random write ack", wack[i], 1);
        model_wr(off + i, wbuf[i]);
      end
      do_read(7'h64, {1'b0, 7'(off)}, 5);
      for (int i = 0; i < 4; i++) chk("R3 random block read", rbuf[i], exp_rd(off + i));
      chk("R6 random tail released", rbuf[4], 8'hFF);
      chk("R10 idle after stop", sda_oe, 0);
    end

    finish_run();
  end
endmodule